// File: doc/BRIEF.md
# Interval Timer with Narrow Compare Window

This block keeps a wide, free-running tick counter that software can read at any time. The counter advances once every four base-clock cycles, so a 1 GHz base clock gives a 250 MHz tick. Software arms a one-shot interrupt by writing a value that is only 32 bits wide. The block turns that narrow value into a full-width target. The counter's upper bits become the upper bits of the target. If that candidate is not far enough ahead of the present count, the block moves it one whole 2^32-tick window later.

When the armed counter reaches or passes the target, the block raises a level interrupt. The interrupt stays high until software clears it or writes a new compare value. Each compare write fires the interrupt at most once. The interrupt controller that consumes the request is outside this block.

Top module: `itimer_top`

## Requirements
- R1: After reset the count reads 0, the stored target reads 0 and the interrupt is low.
- R2: The count advances by exactly one on every fourth clock cycle and holds its value in between.
- R3: The count output always shows the current counter value, with no read strobe needed.
- R4: A compare write forms a candidate target. Its upper bits are the count's upper bits at the write edge, and its low 32 bits are the written value.
- R5: If the candidate is less than the write-edge count plus 250, the stored target is the candidate plus 2^32. A candidate exactly 250 ahead is stored unchanged.
- R6: While armed, the interrupt rises on the clock edge after the edge at which the count first becomes equal to or greater than the target.
- R7: Once raised, the interrupt stays high until a clear strobe or a compare write.
- R8: A clear strobe drops the interrupt on the next edge. The interrupt does not rise again until a new compare write, even though the count stays past the target.
- R9: A compare write drops a pending interrupt on its edge and re-arms the block for the new target.
- R10: Between reset and the first compare write, no interrupt is raised, even though the count is already at or past the reset target of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_val | input | 32 | Written compare value |
| irq_clr | input | 1 | Interrupt clear strobe |
| timer_value | output | 64 | Current tick count |
| cmp_target | output | 64 | Full-width target now held |
| irq | output | 1 | Level interrupt request |

## Verification
The margin boundary is the sharpest corner. The bench writes values 249 and 250 ticks ahead of the count at the write edge. A design with an off-by-one margin, or one that compares against the next count, stores the wrong window for one of them.

A value behind the present count must land a full window later. A design that skips the push would fire at once, so the bench also watches the interrupt stay low.

The interrupt edge is checked cycle-exactly against the moment the count reaches the target, which catches an early comparator or an extra register stage. After a clear, the bench waits with the count past the target. A design that does not disarm on fire would assert the interrupt again.

The bench also checks the idle interval after reset. A design that does not hold the interrupt back until the first write would fire against the reset target of 0.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  // Events that act on the interrupt flag in one cycle
  typedef struct packed {
    logic load;   // compare write
    logic hit;    // armed count reached target
    logic clear;  // software clear
  } irq_evt_t;
endpackage

// File: rtl/itimer_prescale.sv
module itimer_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/itimer_counter.sv
module itimer_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/itimer_cmp.sv
module itimer_cmp
  import itimer_pkg::*;
#(
  parameter int CNT_W        = 64,
  parameter int CMP_W        = 32,
  parameter int MARGIN_TICKS = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_wr,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] target,
  output logic             irq
);
  localparam logic [CNT_W-1:0] WINDOW     = {{(CNT_W-1){1'b0}}, 1'b1} << CMP_W;
  localparam logic [CNT_W:0]   MARGIN_EXT = (CNT_W+1)'(MARGIN_TICKS);

  // Narrow compare value to full-width target, pushed one window on if too close
  function automatic logic [CNT_W-1:0] place_target(
    input logic [CNT_W-1:0] now,
    input logic [CMP_W-1:0] val
  );
    logic [CNT_W-1:0] cand;
    logic [CNT_W:0]   limit;
    cand  = {now[CNT_W-1:CMP_W], val};
    limit = {1'b0, now} + MARGIN_EXT;
    if ({1'b0, cand} < limit) cand = cand + WINDOW;
    return cand;
  endfunction

  logic     armed;
  logic     reached;
  irq_evt_t evt;

  assign reached   = (cnt >= target);
  assign evt.load  = cmp_wr;
  assign evt.hit   = armed && reached;
  assign evt.clear = irq_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
      armed  <= 1'b0;
      irq    <= 1'b0;
    end else if (evt.load) begin
      target <= place_target(cnt, cmp_val);
      armed  <= 1'b1;
      irq    <= 1'b0;
    end else if (evt.hit) begin
      armed  <= 1'b0;
      irq    <= 1'b1;
    end else if (evt.clear) begin
      irq    <= 1'b0;
    end
  end

  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> target[CMP_W-1:0] == $past(cmp_val));
  // R5
  margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> ({1'b0, target} >= {1'b0, $past(cnt)} + MARGIN_EXT));
  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt.hit));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr && !cmp_wr |=> irq);
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.hit && !cmp_wr |=> !armed);
  // R9
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !irq && armed);
endmodule

// File: rtl/itimer_top.sv
module itimer_top #(
  parameter int CNT_W        = 64,
  parameter int CMP_W        = 32,
  parameter int DIV          = 4,
  parameter int MARGIN_TICKS = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] timer_value,
  output logic [CNT_W-1:0] cmp_target,
  output logic             irq
);
  logic tick;

  itimer_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  itimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(timer_value)
  );

  itimer_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W), .MARGIN_TICKS(MARGIN_TICKS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(timer_value),
    .cmp_wr(cmp_wr), .cmp_val(cmp_val), .irq_clr(irq_clr),
    .target(cmp_target), .irq(irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> timer_value == '0 && !irq);
endmodule

// File: tb/tb_itimer_top.sv
module tb_itimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [31:0] cmp_val = '0;
  logic        irq_clr = 1'b0;
  logic [63:0] timer_value, cmp_target;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [63:0] WIN = 64'h1_0000_0000;

  always #5 clk = ~clk;

  itimer_top dut (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_val(cmp_val),
    .irq_clr(irq_clr), .timer_value(timer_value), .cmp_target(cmp_target),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected placement restated from the requirements
  function automatic logic [63:0] want_target(input logic [63:0] now, input logic [31:0] v);
    logic [63:0] c;
    c = {now[63:32], v};
    if (c < now + 64'd250) c = c + WIN;
    return c;
  endfunction

  // Write at a negedge; returns expected target, visible by the next negedge
  task automatic do_write(input logic [31:0] v, output logic [63:0] exp_t);
    @(negedge clk);
    cmp_val = v;
    cmp_wr  = 1'b1;
    exp_t   = want_target(timer_value, v);
    @(negedge clk);
    cmp_wr  = 1'b0;
  endtask

  task automatic wait_count(input logic [63:0] goal);
    int n = 0;
    while (timer_value < goal && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 count", timer_value, 64'd0);
    chk("R1 target", cmp_target, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_prescale;
    logic [63:0] v0;
    int changes = 0;
    v0 = timer_value;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] prev;
      prev = timer_value;
      @(negedge clk);
      if (timer_value != prev) changes++;
    end
    chk("R2 ticks in 40 cycles", 64'(changes), 64'd10);
    chk("R3 count after 40 cycles", timer_value, v0 + 64'd10);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 100; i++) @(negedge clk);
    chk("R10 no irq before first write", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_margin_edge;
    logic [63:0] e;
    do_write(timer_value[31:0] + 32'd250, e);
    chk("R5 margin exact kept", cmp_target, e);
    chk("R4 upper bits", cmp_target[63:32], 64'(timer_value[63:32]));
    do_write(timer_value[31:0] + 32'd249, e);
    chk("R5 one short pushed", cmp_target, e);
    chk("R5 pushed past window", {63'd0, cmp_target >= WIN}, 64'd1);
  endtask

  task automatic t_past_value;
    logic [63:0] e;
    do_write(timer_value[31:0] - 32'd5, e);
    chk("R5 past value pushed", cmp_target, e);
    for (int i = 0; i < 200; i++) @(negedge clk);
    chk("R5 no early fire", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_fire_and_clear;
    logic [63:0] e;
    do_write(timer_value[31:0] + 32'd300, e);
    chk("R4 near target", cmp_target, e);
    wait_count(e);
    chk("R6 count reached", timer_value, e);
    chk("R6 irq not early", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R6 irq rises", {63'd0, irq}, 64'd1);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk("R7 irq held", {63'd0, irq}, 64'd1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 clear drops irq", {63'd0, irq}, 64'd0);
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk("R8 no refire", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_rewrite;
    logic [63:0] e;
    do_write(timer_value[31:0] + 32'd260, e);
    wait_count(e);
    @(negedge clk);
    @(negedge clk);
    chk("R9 setup irq high", {63'd0, irq}, 64'd1);
    do_write(timer_value[31:0] + 32'd400, e);
    chk("R9 write drops irq", {63'd0, irq}, 64'd0);
    wait_count(e);
    @(negedge clk);
    chk("R9 re-armed fires", {63'd0, irq}, 64'd1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_idle();
    t_margin_edge();
    t_past_value();
    t_fire_and_clear();
    t_rewrite();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule